// File: doc/BRIEF.md
# Priority-Encoded Content-Addressable Memory

This block is a small associative store of sixteen 8-bit entries. A single port serves two kinds of access. A write puts a data word into one entry chosen by an address. A lookup compares a search key against all sixteen entries at once and returns the index of a matching entry.

When several entries hold the key, the lookup reports the highest index among them. Lookup has priority over write: if both are requested in the same cycle, only the lookup is carried out. The result is registered, so it appears on the outputs after the clock edge that samples the lookup request. Cycles without a lookup, and lookups that find nothing, leave a zero index and a cleared hit flag.

Entry contents are undefined until they are written. The block is meant for small tag or key tables, where a caller writes keys at chosen slots and later asks where a key is stored.

Top module: `prio_cam`

## Requirements
- R1: The store holds 16 entries of 8 bits each, selected by a 4-bit address; all of these sizes are parameters.
- R2: When wr_en=1 and rd_en=0 at a rising edge, key is stored in entry addr, and a lookup on the next cycle sees the new value.
- R3: When rd_en=1 and exactly one entry equals key, then after that edge match_hit=1 and match_idx is that entry's index, including indices 0 and 15.
- R4: When rd_en=1 and several entries equal key, match_idx is the largest matching index and match_hit=1.
- R5: When rd_en=1 and no entry equals key, match_idx=0 and match_hit=0 after the edge.
- R6: When wr_en=1 and rd_en=1 together, the lookup is performed and the write is discarded, so the addressed entry keeps its old value.
- R7: When rd_en=0 at an edge, whether or not a write happens, match_idx=0 and match_hit=0 after that edge.
- R8: The outputs are registered: they change only at a rising edge, and they hold their value while the inputs change between edges.
- R9: rst is synchronous and active high; while it is sampled high, match_idx=0 and match_hit=0, even if a lookup is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the result registers |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Lookup request; takes priority over wr_en |
| addr | input | 4 | Entry selected by a write |
| key | input | 8 | Write data, or the search key for a lookup |
| match_idx | output | 4 | Registered index of the highest matching entry, 0 when there is no hit |
| match_hit | output | 1 | Registered flag, 1 when the last lookup found a match |

## Verification
The bench places one key in three slots and checks that the highest slot is reported. A priority encoder that scans from the wrong end would return the lowest slot instead. The bench also issues a lookup together with a write aimed at a higher slot. A design that lets the write through would report that slot on the following lookup. Further cases are matches at slots 0 and 15, a miss that must clear a stale hit, a lookup right after a write, output stability between edges, and a reset that overrides a pending lookup.

// File: rtl/cam_pkg.sv
package cam_pkg;

    localparam int CAM_DEPTH = 16;
    localparam int CAM_WIDTH = 8;
    localparam int CAM_AW    = $clog2(CAM_DEPTH);

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } cam_op_e;

    typedef struct packed {
        logic              hit;
        logic [CAM_AW-1:0] idx;
    } cam_result_t;

    // Lookup wins over write; a write alone stores; otherwise idle.
    function automatic cam_op_e decode_op(input logic wr, input logic rd);
        if (rd)
            return OP_READ;
        else if (wr)
            return OP_WRITE;
        else
            return OP_IDLE;
    endfunction

endpackage

// File: rtl/cam_store.sv
module cam_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] entries [DEPTH]
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem_q[waddr] <= wdata;
    end

    assign entries = mem_q;

endmodule

// File: rtl/cam_compare.sv
module cam_compare #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] entries [DEPTH],
    input  logic [WIDTH-1:0] key,
    output logic [DEPTH-1:0] match_vec
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match_vec[g] = (entries[g] == key);
    end

endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] match_vec,
    output logic             found,
    output logic [AW-1:0]    idx
);

    // Ascending scan: a later (higher) index overrides an earlier one.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match_vec[i]) begin
                found = 1'b1;
                idx   = AW'(i);
            end
        end
    end

endmodule

// File: rtl/prio_cam.sv
module prio_cam
    import cam_pkg::*;
#(
    parameter int DEPTH = CAM_DEPTH,
    parameter int WIDTH = CAM_WIDTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] key,
    output logic [AW-1:0]    match_idx,
    output logic             match_hit
);

    cam_op_e          op;
    logic [WIDTH-1:0] entries [DEPTH];
    logic [DEPTH-1:0] match_vec;
    logic             found;
    logic [AW-1:0]    found_idx;
    logic             hit_q;
    logic [AW-1:0]    idx_q;

    assign op = decode_op(wr_en, rd_en);

    cam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .we      (op == OP_WRITE),
        .waddr   (addr),
        .wdata   (key),
        .entries (entries)
    );

    cam_compare #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_cmp (
        .entries   (entries),
        .key       (key),
        .match_vec (match_vec)
    );

    cam_prio_enc #(.DEPTH(DEPTH)) u_enc (
        .match_vec (match_vec),
        .found     (found),
        .idx       (found_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            idx_q <= '0;
        end else if (op == OP_READ) begin
            hit_q <= found;
            idx_q <= found ? found_idx : '0;
        end else begin
            hit_q <= 1'b0;
            idx_q <= '0;
        end
    end

    assign match_hit = hit_q;
    assign match_idx = idx_q;

endmodule

// File: rtl/prio_cam_chk.sv
module prio_cam_chk #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic [AW-1:0]    addr,
    input logic [WIDTH-1:0] key,
    input logic [AW-1:0]    match_idx,
    input logic             match_hit,
    input logic [WIDTH-1:0] entries [DEPTH]
);

    logic [WIDTH-1:0] key_q;
    logic             higher_match;

    always_ff @(posedge clk) key_q <= key;

    always_comb begin
        higher_match = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (AW'(i) > match_idx && entries[i] == key_q)
                higher_match = 1'b1;
    end

    // R2: a lone write lands in the addressed entry
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en) |=> entries[$past(addr)] == $past(key));

    // R3: a reported hit points at an entry holding the key
    a_r3_hit_is_match: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (!match_hit || entries[match_idx] == $past(key)));

    // R4: no higher index also holds the key
    a_r4_highest_wins: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (!match_hit || !higher_match));

    // R5: without a hit the index reads zero
    a_r5_miss_zero_idx: assert property (@(posedge clk) disable iff (rst)
        !match_hit |-> match_idx == '0);

    // R6: write request alongside a lookup leaves the entry unchanged
    a_r6_rw_drops_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> entries[$past(addr)] == $past(entries[addr]));

    // R7: no lookup gives cleared outputs
    a_r7_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!match_hit && match_idx == '0));

endmodule

bind prio_cam prio_cam_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .key       (key),
    .match_idx (match_idx),
    .match_hit (match_hit),
    .entries   (entries)
);

// File: tb/prio_cam_test.sv
module prio_cam_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] key = '0;
    logic [3:0] match_idx;
    logic       match_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    prio_cam uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .key(key), .match_idx(match_idx), .match_hit(match_hit)
    );

    // vector: we, re, addr[4], key[8], exp_hit, exp_idx[4], req[5]
    localparam int NV = 14;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'd3,  8'h55, 1'b0, 4'd0,  5'd2},
        {1'b0, 1'b1, 4'd0,  8'h55, 1'b1, 4'd3,  5'd3},
        {1'b1, 1'b0, 4'd9,  8'h55, 1'b0, 4'd0,  5'd7},
        {1'b0, 1'b1, 4'd0,  8'h55, 1'b1, 4'd9,  5'd4},
        {1'b1, 1'b0, 4'd14, 8'h55, 1'b0, 4'd0,  5'd7},
        {1'b0, 1'b1, 4'd0,  8'h55, 1'b1, 4'd14, 5'd4},
        {1'b0, 1'b1, 4'd0,  8'h7F, 1'b0, 4'd0,  5'd5},
        {1'b0, 1'b1, 4'd0,  8'hA0, 1'b1, 4'd0,  5'd3},
        {1'b0, 1'b1, 4'd0,  8'hAF, 1'b1, 4'd15, 5'd3},
        {1'b1, 1'b1, 4'd15, 8'h55, 1'b1, 4'd14, 5'd6},
        {1'b0, 1'b1, 4'd0,  8'h55, 1'b1, 4'd14, 5'd6},
        {1'b0, 1'b0, 4'd0,  8'h55, 1'b0, 4'd0,  5'd7},
        {1'b1, 1'b0, 4'd0,  8'hAF, 1'b0, 4'd0,  5'd2},
        {1'b0, 1'b1, 4'd0,  8'hAF, 1'b1, 4'd15, 5'd4}
    };

    task automatic check(input string req, input logic ah, input logic [3:0] ai,
                         input logic eh, input logic [3:0] ei);
        checks++;
        if (ah !== eh || ai !== ei) begin
            fails++;
            $display("FAIL %s: got hit=%b idx=%0d, expected hit=%b idx=%0d",
                     req, ah, ai, eh, ei);
        end
    endtask

    task automatic step(input logic w, input logic r, input logic [3:0] a,
                        input logic [7:0] k);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; key = k;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset", match_hit, match_idx, 1'b0, 4'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1/R2: fill all 16 slots with distinct values A0..AF; outputs stay clear (R7)
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b0, 4'(i), 8'hA0 + 8'(i));
            check("R7 write cycle", match_hit, match_idx, 1'b0, 4'd0);
        end

        for (int v = 0; v < NV; v++) begin
            string tag;
            step(VEC[v][23], VEC[v][22], VEC[v][21:18], VEC[v][17:10]);
            tag = $sformatf("R%0d vec%0d", VEC[v][4:0], v);
            check(tag, match_hit, match_idx, VEC[v][9], VEC[v][8:5]);
        end

        // R2: lookup directly after a write sees the new value
        step(1'b1, 1'b0, 4'd5, 8'hC3);
        step(1'b0, 1'b1, 4'd0, 8'hC3);
        check("R2 read after write", match_hit, match_idx, 1'b1, 4'd5);

        // R5: miss clears a stale hit
        step(1'b0, 1'b1, 4'd0, 8'h00);
        check("R5 miss after hit", match_hit, match_idx, 1'b0, 4'd0);

        // R8: outputs hold between edges
        step(1'b0, 1'b1, 4'd0, 8'hAF);
        @(negedge clk);
        rd_en = 1'b1; key = 8'h7E;
        #1;
        check("R8 hold before edge", match_hit, match_idx, 1'b1, 4'd15);
        @(posedge clk);
        #1;
        check("R8 update at edge", match_hit, match_idx, 1'b0, 4'd0);

        // R9: reset wins over a pending lookup
        step(1'b0, 1'b1, 4'd0, 8'hC3);
        @(negedge clk);
        rst = 1'b1; rd_en = 1'b1; key = 8'hC3;
        @(posedge clk);
        #1;
        check("R9 reset over lookup", match_hit, match_idx, 1'b0, 4'd0);
        @(negedge clk);
        rst = 1'b0; rd_en = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule